// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a shared memory slave and watches its read-address and write-address handshakes. It lets several masters run read-modify-write semaphores without taking the bus. An exclusive read from a master records a reservation: the master's transaction ID and the aligned address window that the read touched. Any later write from another ID that lands in that window breaks the reservation. When the master then issues its exclusive write, the monitor checks whether the reservation is still intact. On success the memory write goes ahead and the response code is EXOKAY. On failure the write is suppressed and the response code is OKAY, so the memory keeps the data the other master wrote.

The monitor never stalls either channel. Ordinary traffic keeps flowing at full rate while reservations are active, and the monitor only observes completed handshakes. For each write-address handshake it produces one registered decision, one cycle later. That decision carries a commit enable for the memory write path (strobes are gated low when commit is low), the response code for the write response channel, and the ID it applies to. The table of reservations is small and fixed in size. When the table is full, the reservation that was set least recently gives way to a new one.

Top module: `excl_monitor`

## Requirements
- R1: While reset is held and after it is released, no decision is issued and the reservation table is empty, so an exclusive write with no exclusive read since reset fails.
- R2: A read handshake with lock code 01 reserves, for its ID, the aligned window of 2^WIN_LG bytes holding its address. Reads with lock codes 00, 10 or 11 reserve nothing.
- R3: An exclusive write (lock 01) whose ID holds a reservation for the window of its address gives commit 1 and response 01 (EXOKAY).
- R4: An exclusive write without such a reservation gives commit 0 and response 00 (OKAY), and leaves every reservation unchanged.
- R5: A successful exclusive write clears every reservation on its window, whatever the ID. Reservations on other windows survive.
- R6: A write with lock 00, 10 or 11 always gives commit 1 and response 00. It clears the reservations of other IDs on its window and keeps the reservation of its own ID.
- R7: An exclusive read from an ID that already holds a reservation replaces that reservation's window.
- R8: The table holds ENTRIES reservations. A new ID arriving when the table is full evicts the reservation whose last set or refresh is the oldest.
- R9: When a read and a write complete in the same cycle, the write is judged and applied first, and the read's reservation is recorded afterwards.
- R10: Each write handshake yields exactly one decision with rsp_valid_o high in the following cycle, with rsp_id_o equal to the write's ID. No decision appears in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ar_fire_i | input | 1 | Read-address handshake completes this cycle |
| ar_id_i | input | ID_W | Read transaction ID |
| ar_addr_i | input | ADDR_W | Read start address |
| ar_lock_i | input | 2 | Read access type: 00 normal, 01 exclusive, 10 locked, 11 reserved |
| aw_fire_i | input | 1 | Write-address handshake completes this cycle |
| aw_id_i | input | ID_W | Write transaction ID |
| aw_addr_i | input | ADDR_W | Write start address |
| aw_lock_i | input | 2 | Write access type, same coding as reads |
| rsp_valid_o | output | 1 | Decision for the previous cycle's write handshake |
| rsp_commit_o | output | 1 | Write may update memory (strobes are forced low when 0) |
| rsp_bresp_o | output | 2 | Write response code: 00 OKAY, 01 EXOKAY |
| rsp_id_o | output | ID_W | ID of the write the decision belongs to |

## Verification
The bench targets the ways a reservation can be lost or wrongly kept. It covers a foreign write in the same window but at a different byte offset, a plain write from the owner itself, a locked-type write, a second exclusive read from the same ID moving the window, and a full table where a refreshed entry has to survive while the truly oldest one goes. A design that compared whole addresses would let the offset write slip through. A design that ignored IDs on plain writes would fail the owner's later exclusive write. A design that replaced entries in slot order would evict the refreshed ID instead of the stale one. A read and a write completing in the same cycle check the ordering: if a design applied the read first, the fresh reservation would be killed at once. A long random phase with few IDs and windows compares every decision against a behavioural queue model.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

    // Access-type coding carried on the lock fields
    typedef enum logic [1:0] {
        LK_NORMAL = 2'b00,
        LK_EXCL   = 2'b01,
        LK_LOCKED = 2'b10,
        LK_RSVD   = 2'b11
    } lock_e;

    // Write response codes produced by the monitor
    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01
    } resp_e;

endpackage

// File: rtl/exmon_match.sv
// Per-entry comparison of a query ID and window tag against the table.
module exmon_match #(
    parameter int ENTRIES = 4,
    parameter int ID_W    = 4,
    parameter int TAG_W   = 28
) (
    input  logic [ENTRIES-1:0]            ent_vld,
    input  logic [ENTRIES-1:0][ID_W-1:0]  ent_id,
    input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
    input  logic [ID_W-1:0]               q_id,
    input  logic [TAG_W-1:0]              q_tag,
    output logic [ENTRIES-1:0]            id_hit,
    output logic [ENTRIES-1:0]            tag_hit
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign id_hit[e]  = ent_vld[e] && (ent_id[e] == q_id);
        assign tag_hit[e] = ent_vld[e] && (ent_tag[e] == q_tag);
    end

endmodule

// File: rtl/exmon_alloc.sv
// Keeps a dense age ranking of surviving entries (0 = youngest) and
// chooses the slot for a new reservation: same ID, else a free slot,
// else the oldest entry.
module exmon_alloc #(
    parameter int ENTRIES = 4,
    parameter int ID_W    = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          req,
    input  logic [ENTRIES-1:0]            keep,
    input  logic [ENTRIES-1:0][ID_W-1:0]  ent_id,
    input  logic [ID_W-1:0]               rd_id,
    input  logic [ENTRIES-1:0][IDX_W-1:0] age_q,
    output logic [IDX_W-1:0]              slot,
    output logic [ENTRIES-1:0][IDX_W-1:0] age_d
);

    logic [ENTRIES-1:0][IDX_W-1:0] rank;
    logic [ENTRIES-1:0]            same;

    // Compact ranks after invalidations: rank = number of younger survivors
    always_comb begin
        rank = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (keep[i] && keep[j] && (age_q[j] < age_q[i])) begin
                    rank[i] = rank[i] + 1'b1;
                end
            end
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_same
        assign same[e] = keep[e] && (ent_id[e] == rd_id);
    end

    // Slot choice
    always_comb begin
        logic found;
        found = 1'b0;
        slot  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && same[i]) begin
                slot  = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !keep[i]) begin
                slot  = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && (rank[i] == IDX_W'(ENTRIES - 1))) begin
                slot  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    // Next ages: chosen slot becomes youngest, those younger than it shift
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!req) begin
                age_d[i] = rank[i];
            end else if (IDX_W'(i) == slot) begin
                age_d[i] = '0;
            end else if (keep[i] && (!keep[slot] || (rank[i] < rank[slot]))) begin
                age_d[i] = rank[i] + 1'b1;
            end else begin
                age_d[i] = rank[i];
            end
        end
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import exmon_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 32,
    parameter int WIN_LG  = 4,
    parameter int ENTRIES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ar_fire_i,
    input  logic [ID_W-1:0]   ar_id_i,
    input  logic [ADDR_W-1:0] ar_addr_i,
    input  logic [1:0]        ar_lock_i,
    input  logic              aw_fire_i,
    input  logic [ID_W-1:0]   aw_id_i,
    input  logic [ADDR_W-1:0] aw_addr_i,
    input  logic [1:0]        aw_lock_i,
    output logic              rsp_valid_o,
    output logic              rsp_commit_o,
    output logic [1:0]        rsp_bresp_o,
    output logic [ID_W-1:0]   rsp_id_o
);

    localparam int TAG_W = ADDR_W - WIN_LG;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][ID_W-1:0]  id;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][IDX_W-1:0] age;
        logic                          rsp_v;
        logic                          rsp_c;
        logic [1:0]                    rsp_b;
        logic [ID_W-1:0]               rsp_id;
    } state_t;

    state_t st_q, st_d;

    logic [TAG_W-1:0]              wr_tag, rd_tag;
    logic [ENTRIES-1:0]            w_id_hit, w_tag_hit, clr, keep;
    logic                          w_excl, w_ok, r_excl;
    logic [IDX_W-1:0]              new_slot;
    logic [ENTRIES-1:0][IDX_W-1:0] age_nxt;
    logic [ENTRIES-1:0]            ent_valid_q;

    assign wr_tag = TAG_W'(aw_addr_i >> WIN_LG);
    assign rd_tag = TAG_W'(ar_addr_i >> WIN_LG);
    assign w_excl = aw_fire_i && (aw_lock_i == LK_EXCL);
    assign r_excl = ar_fire_i && (ar_lock_i == LK_EXCL);

    exmon_match #(
        .ENTRIES (ENTRIES),
        .ID_W    (ID_W),
        .TAG_W   (TAG_W)
    ) u_wmatch (
        .ent_vld (st_q.vld),
        .ent_id  (st_q.id),
        .ent_tag (st_q.tag),
        .q_id    (aw_id_i),
        .q_tag   (wr_tag),
        .id_hit  (w_id_hit),
        .tag_hit (w_tag_hit)
    );

    assign w_ok = w_excl && |(w_id_hit & w_tag_hit);

    // Write is judged on the registered table, then clears what it breaks
    always_comb begin
        if (!aw_fire_i) begin
            clr = '0;
        end else if (w_excl) begin
            clr = w_ok ? w_tag_hit : '0;
        end else begin
            clr = w_tag_hit & ~w_id_hit;
        end
        keep = st_q.vld & ~clr;
    end

    exmon_alloc #(
        .ENTRIES (ENTRIES),
        .ID_W    (ID_W)
    ) u_alloc (
        .req    (r_excl),
        .keep   (keep),
        .ent_id (st_q.id),
        .rd_id  (ar_id_i),
        .age_q  (st_q.age),
        .slot   (new_slot),
        .age_d  (age_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = keep;
        st_d.age = age_nxt;
        if (r_excl) begin
            st_d.vld[new_slot] = 1'b1;
            st_d.id[new_slot]  = ar_id_i;
            st_d.tag[new_slot] = rd_tag;
        end
        st_d.rsp_v = aw_fire_i;
        st_d.rsp_c = aw_fire_i && (!w_excl || w_ok);
        st_d.rsp_b = w_ok ? RSP_EXOKAY : RSP_OKAY;
        if (aw_fire_i) begin
            st_d.rsp_id = aw_id_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_valid_q  = st_q.vld;
    assign rsp_valid_o  = st_q.rsp_v;
    assign rsp_commit_o = st_q.rsp_c;
    assign rsp_bresp_o  = st_q.rsp_b;
    assign rsp_id_o     = st_q.rsp_id;

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
    parameter int ID_W    = 4,
    parameter int ENTRIES = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               ar_fire_i,
    input logic [1:0]         ar_lock_i,
    input logic               aw_fire_i,
    input logic [ID_W-1:0]    aw_id_i,
    input logic [1:0]         aw_lock_i,
    input logic               rsp_valid_o,
    input logic               rsp_commit_o,
    input logic [1:0]         rsp_bresp_o,
    input logic [ID_W-1:0]    rsp_id_o,
    input logic [ENTRIES-1:0] tbl_vld
);

    // R10
    rsp_follows_aw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aw_fire_i |=> rsp_valid_o);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !aw_fire_i |=> !rsp_valid_o);

    // R10
    rsp_id_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aw_fire_i |=> (rsp_id_o == $past(aw_id_i)));

    // R6
    plain_write_commits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aw_fire_i && aw_lock_i != 2'b01) |=> (rsp_commit_o && rsp_bresp_o == 2'b00));

    // R4
    empty_table_fails_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aw_fire_i && aw_lock_i == 2'b01 && tbl_vld == '0) |=>
        (!rsp_commit_o && rsp_bresp_o == 2'b00));

    // R3
    exokay_only_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_bresp_o == 2'b01) |-> (rsp_commit_o && $past(aw_lock_i) == 2'b01));

    // R2
    excl_read_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ar_fire_i && ar_lock_i == 2'b01) |=> (tbl_vld != '0));

    // R2
    plain_read_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!aw_fire_i && !(ar_fire_i && ar_lock_i == 2'b01)) |=> $stable(tbl_vld));

    // R1
    idle_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_valid_o |-> !rsp_commit_o);

endmodule

bind excl_monitor excl_monitor_chk #(
    .ID_W    (ID_W),
    .ENTRIES (ENTRIES)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ar_fire_i    (ar_fire_i),
    .ar_lock_i    (ar_lock_i),
    .aw_fire_i    (aw_fire_i),
    .aw_id_i      (aw_id_i),
    .aw_lock_i    (aw_lock_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_commit_o (rsp_commit_o),
    .rsp_bresp_o  (rsp_bresp_o),
    .rsp_id_o     (rsp_id_o),
    .tbl_vld      (ent_valid_q)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ID_W = 4, ADDR_W = 32, WIN_LG = 4, ENTRIES = 4;
    localparam logic [1:0] NRM = 2'b00, EXC = 2'b01, LCK = 2'b10, RSV = 2'b11;
    localparam logic [31:0] A  = 32'h1000_0040;
    localparam logic [31:0] B  = 32'h1000_0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ar_fire = 1'b0, aw_fire = 1'b0;
    logic [ID_W-1:0] ar_id = '0, aw_id = '0;
    logic [ADDR_W-1:0] ar_addr = '0, aw_addr = '0;
    logic [1:0] ar_lock = '0, aw_lock = '0;
    logic rsp_valid, rsp_commit;
    logic [1:0] rsp_bresp;
    logic [ID_W-1:0] rsp_id;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    excl_monitor #(
        .ID_W (ID_W), .ADDR_W (ADDR_W), .WIN_LG (WIN_LG), .ENTRIES (ENTRIES)
    ) u_excl_monitor (
        .clk_i (clk), .rst_ni (rst_n),
        .ar_fire_i (ar_fire), .ar_id_i (ar_id), .ar_addr_i (ar_addr), .ar_lock_i (ar_lock),
        .aw_fire_i (aw_fire), .aw_id_i (aw_id), .aw_addr_i (aw_addr), .aw_lock_i (aw_lock),
        .rsp_valid_o (rsp_valid), .rsp_commit_o (rsp_commit),
        .rsp_bresp_o (rsp_bresp), .rsp_id_o (rsp_id)
    );

    // Behavioural model: queue of reservations, front is youngest
    typedef struct { int id; int tag; } res_t;
    res_t rq[$];

    function automatic int win(input logic [31:0] a);
        return int'(a >> WIN_LG);
    endfunction

    task automatic check(input string req, input bit ev, input bit ec, input int eb, input int eid);
        n_chk++;
        if (rsp_valid !== ev || (rsp_commit !== ec) || (ev && (int'(rsp_bresp) != eb))
            || (ev && int'(rsp_id) != eid)) begin
            n_fail++;
            $display("FAIL %s: valid/commit/bresp/id got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     req, rsp_valid, rsp_commit, rsp_bresp, rsp_id, ev, ec, eb, eid);
        end
    endtask

    // One clock: drive at negedge, model, check at next negedge
    task automatic cyc(input bit arf, input int arid, input logic [31:0] araddr, input logic [1:0] arlk,
                       input bit awf, input int awid, input logic [31:0] awaddr, input logic [1:0] awlk,
                       input string req);
        bit ev, ec;
        int eb;
        ar_fire = arf; ar_id = ID_W'(arid); ar_addr = araddr; ar_lock = arlk;
        aw_fire = awf; aw_id = ID_W'(awid); aw_addr = awaddr; aw_lock = awlk;
        ev = awf; ec = 1'b0; eb = 0;
        if (awf) begin
            if (awlk == EXC) begin
                bit hit = 1'b0;
                foreach (rq[i]) if (rq[i].id == awid && rq[i].tag == win(awaddr)) hit = 1'b1;
                if (hit) begin
                    ec = 1'b1; eb = 1;
                    for (int i = rq.size() - 1; i >= 0; i--)
                        if (rq[i].tag == win(awaddr)) rq.delete(i);
                end
            end else begin
                ec = 1'b1;
                for (int i = rq.size() - 1; i >= 0; i--)
                    if (rq[i].tag == win(awaddr) && rq[i].id != awid) rq.delete(i);
            end
        end
        if (arf && arlk == EXC) begin
            res_t r;
            for (int i = rq.size() - 1; i >= 0; i--)
                if (rq[i].id == arid) rq.delete(i);
            if (rq.size() == ENTRIES) void'(rq.pop_back());
            r.id = arid; r.tag = win(araddr);
            rq.push_front(r);
        end
        @(posedge clk);
        @(negedge clk);
        check(req, ev, ec, eb, awid);
    endtask

    task automatic rd(input int id, input logic [31:0] a, input logic [1:0] lk, input string req);
        cyc(1'b1, id, a, lk, 1'b0, 0, 32'h0, NRM, req);
    endtask

    task automatic wr(input int id, input logic [31:0] a, input logic [1:0] lk, input string req);
        cyc(1'b0, 0, 32'h0, NRM, 1'b1, id, a, lk, req);
    endtask

    task automatic do_reset();
        ar_fire = 1'b0; aw_fire = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0, 0, 0);
        rq.delete();
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] wn(input int k);
        return 32'h2000_0000 + 32'(k * 16);
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        cyc(1'b0, 0, 0, NRM, 1'b0, 0, 0, NRM, "R10");       // idle: no decision
        wr(1, A, EXC, "R1");                                 // empty table: fail
        // Basic success, offset inside the window
        rd(1, A, EXC, "R2");
        wr(1, A + 4, EXC, "R3");
        wr(1, A, EXC, "R5");                                 // consumed: fail
        // Foreign plain write at other offset breaks it
        rd(1, A, EXC, "R2");
        wr(2, A + 8, NRM, "R6");
        wr(1, A, EXC, "R6");
        // Owner's plain write keeps it
        rd(1, A, EXC, "R2");
        wr(1, A, NRM, "R6");
        wr(1, A, EXC, "R6");
        // Foreign write elsewhere keeps it
        rd(1, A, EXC, "R2");
        wr(2, B, NRM, "R6");
        wr(1, A, EXC, "R6");
        // Locked and reserved types behave as plain writes
        rd(1, A, EXC, "R2");
        wr(3, A, LCK, "R6");
        wr(1, A, EXC, "R6");
        rd(1, A, EXC, "R2");
        wr(3, A + 1, RSV, "R6");
        wr(1, A, EXC, "R6");
        // Non-exclusive reads reserve nothing
        rd(1, A, NRM, "R2");
        wr(1, A, EXC, "R2");
        rd(1, A, LCK, "R2");
        wr(1, A, EXC, "R2");
        // Success clears other IDs on the window, not elsewhere
        rd(1, A, EXC, "R2");
        rd(2, A, EXC, "R2");
        rd(3, B, EXC, "R2");
        wr(1, A, EXC, "R5");
        wr(2, A, EXC, "R5");
        wr(3, B, EXC, "R5");
        // Failed exclusive writes leave the table alone
        rd(1, A, EXC, "R4");
        wr(1, B, EXC, "R4");
        wr(2, A, EXC, "R4");
        wr(1, A, EXC, "R4");
        // Same ID moves its window
        rd(1, A, EXC, "R7");
        rd(1, B, EXC, "R7");
        wr(1, A, EXC, "R7");
        wr(1, B, EXC, "R7");
        // Capacity: fifth ID evicts the oldest
        do_reset();
        for (int k = 1; k <= 5; k++) rd(k, wn(k), EXC, "R8");
        wr(1, wn(1), EXC, "R8");
        wr(2, wn(2), EXC, "R8");
        // Refresh protects an entry; next oldest goes
        do_reset();
        for (int k = 1; k <= 4; k++) rd(k, wn(k), EXC, "R8");
        rd(1, wn(1), EXC, "R8");
        rd(5, wn(5), EXC, "R8");
        wr(2, wn(2), EXC, "R8");
        wr(1, wn(1), EXC, "R8");
        wr(3, wn(3), EXC, "R8");
        // Same-cycle read and write: write applies first
        cyc(1'b1, 1, A, EXC, 1'b1, 2, A, NRM, "R9");
        wr(1, A, EXC, "R9");
        cyc(1'b1, 4, B, EXC, 1'b1, 4, B, EXC, "R9");
        wr(4, B, EXC, "R9");
        // Reset drops reservations
        rd(1, A, EXC, "R1");
        do_reset();
        wr(1, A, EXC, "R1");
        // Random traffic against the model
        for (int n = 0; n < 2000; n++) begin
            bit arf = ($urandom_range(0, 2) != 0);
            bit awf = ($urandom_range(0, 1) != 0);
            logic [1:0] al = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : EXC;
            logic [1:0] wl = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : EXC;
            cyc(arf, $urandom_range(0, 5), wn($urandom_range(0, 3)) + 32'($urandom_range(0, 15)), al,
                awf, $urandom_range(0, 5), wn($urandom_range(0, 3)) + 32'($urandom_range(0, 15)), wl,
                "R5");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10: watchdog expired, got hang expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule